// File: doc/BRIEF.md
# Configurable Stereo Serial Audio Transmitter

This block turns left/right pairs of audio samples into a three-wire serial stream: a bit clock, a word-select line that marks the channel, and a serial data line. It can run as the timing master, dividing the system clock down to a bit clock and generating word-select itself. It can also run as a slave that follows a bit clock and word-select supplied from outside. Both external lines are brought into the system clock domain before use.

Four configuration inputs shape the frame. The first picks master or slave. The second says whether word-select leads the first data bit by one bit clock (classic I2S) or switches on that bit (left-justified). The third picks the bit clock edge that launches data. The fourth picks which word-select level stands for the left channel. The configuration is latched only while `enable` is low, so a frame that is in flight cannot be corrupted by a change.

Samples arrive through a valid/ready handshake. The block takes a pair only at the start of a left word. If no pair is offered at that moment, it sends a frame of zeros.

Top module: `stereo_serial_tx`

## Requirements
- R1: With `cfg_master`=1 and `enable` high, `sck_out` toggles every `HALF_DIV` system clocks. With `cfg_master`=0, `sck_out` and `ws_out` stay low and bit timing comes from `sck_in` and `ws_in`.
- R2: With `cfg_ws_lead`=0, the word-select change and the most significant bit of the new word are launched on the same bit clock edge.
- R3: With `cfg_ws_lead`=1, the word-select change is launched one bit clock before the most significant bit of the new word.
- R4: With `cfg_rise_launch`=1, word-select and data change only on a rising bit clock edge. With 0, they change only on a falling edge. The far end samples on the other edge.
- R5: With `cfg_ws_swap`=0, a low word-select marks the left word and a high one marks the right word. With 1, the meaning is reversed.
- R6: Each word is `WORD_BITS` bits, most significant bit first. Word-select holds each level for exactly `WORD_BITS` bit clocks, and each frame sends the left word first.
- R7: `pair_ready` is high for a single system clock, at the bit clock edge that starts a left word. A pair is taken only when `pair_valid` is high in that cycle. If `pair_valid` is low, both words of that frame are zero.
- R8: The configuration inputs are latched only while `enable` is low. Changing them while enabled does not affect the stream.
- R9: After reset, `sck_out`, `ws_out`, `sd_out` and `pair_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the frame engine; configuration is latched while low |
| cfg_master | input | 1 | 1: generate bit clock and word-select; 0: follow external ones |
| cfg_ws_lead | input | 1 | 1: word-select leads the first data bit by one bit clock |
| cfg_rise_launch | input | 1 | 1: launch on rising bit clock edge; 0: on falling edge |
| cfg_ws_swap | input | 1 | 0: low word-select is left; 1: high is left |
| pair_valid | input | 1 | A sample pair is offered |
| pair_ready | output | 1 | Pair taken in this cycle (left-word start) |
| pair_left | input | WORD_BITS | Left channel sample |
| pair_right | input | WORD_BITS | Right channel sample |
| sck_in | input | 1 | External bit clock (slave) |
| ws_in | input | 1 | External word-select (slave) |
| sck_out | output | 1 | Generated bit clock (master), low in slave |
| ws_out | output | 1 | Generated word-select (master), low in slave |
| sd_out | output | 1 | Serial data |

## Verification
In master mode, word-select and data change in the same system clock cycle as the launching `sck_out` edge. In slave mode, they change three system clock edges after the external launch edge: two synchronizer flops, then the edge-compare register. `pair_ready` is asserted during a single cycle, and the pair is captured at the clock edge that closes that cycle. For that reason the driver changes its data only after that edge.

The monitor polls the lines on the falling system clock edge and decodes a bit only at the far-end sampling edge of the bit clock. That is half a bit clock after launch, which is well past both latencies. The decoded words are compared, in order, with a queue of expected left and right words.

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx #(
  parameter int WORD_BITS = 16,
  parameter int HALF_DIV  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 cfg_master,
  input  logic                 cfg_ws_lead,
  input  logic                 cfg_rise_launch,
  input  logic                 cfg_ws_swap,
  input  logic                 pair_valid,
  output logic                 pair_ready,
  input  logic [WORD_BITS-1:0] pair_left,
  input  logic [WORD_BITS-1:0] pair_right,
  input  logic                 sck_in,
  input  logic                 ws_in,
  output logic                 sck_out,
  output logic                 ws_out,
  output logic                 sd_out
);
  localparam int CW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic m_c, lead_c, rise_c, swap_c;
  logic sck_s1, sck_s2, sck_s3, ws_s1, ws_s2;
  logic [DW-1:0] dcnt;
  logic [CW-1:0] bcnt;
  logic sck_q, ws_seen, chg_d;
  logic [WORD_BITS-1:0] sh, rbuf;

  logic half_end, tick, ws_now, chg, start, now_left;

  assign half_end = (dcnt == DW'(HALF_DIV - 1));
  assign tick = enable & (m_c ? (half_end & (sck_q != rise_c))
                              : ((sck_s2 != sck_s3) & (sck_s2 == rise_c)));
  assign ws_now = m_c ? ((bcnt == CW'(WORD_BITS - 1)) ? ~ws_seen : ws_seen) : ws_s2;
  assign chg = (ws_now != ws_seen);
  assign start = lead_c ? chg_d : chg;
  assign now_left = (ws_now == swap_c);
  assign pair_ready = tick & start & now_left;

  assign sck_out = m_c & sck_q;
  assign ws_out  = m_c & ws_seen;
  assign sd_out  = sh[WORD_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s1 <= 1'b0;
      sck_s2 <= 1'b0;
      sck_s3 <= 1'b0;
      ws_s1  <= 1'b0;
      ws_s2  <= 1'b0;
    end else begin
      sck_s1 <= sck_in;
      sck_s2 <= sck_s1;
      sck_s3 <= sck_s2;
      ws_s1  <= ws_in;
      ws_s2  <= ws_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c     <= 1'b0;
      lead_c  <= 1'b0;
      rise_c  <= 1'b0;
      swap_c  <= 1'b0;
      sck_q   <= 1'b0;
      ws_seen <= 1'b0;
      chg_d   <= 1'b0;
      dcnt    <= '0;
      bcnt    <= '0;
      sh      <= '0;
      rbuf    <= '0;
    end else if (!enable) begin
      m_c     <= cfg_master;
      lead_c  <= cfg_ws_lead;
      rise_c  <= cfg_rise_launch;
      swap_c  <= cfg_ws_swap;
      sck_q   <= ~cfg_rise_launch;
      ws_seen <= ~cfg_ws_swap;
      chg_d   <= 1'b0;
      dcnt    <= '0;
      bcnt    <= CW'(WORD_BITS - 1);
      sh      <= '0;
      rbuf    <= '0;
    end else begin
      if (m_c) begin
        dcnt <= half_end ? '0 : dcnt + DW'(1);
        if (half_end) sck_q <= ~sck_q;
      end
      if (tick) begin
        ws_seen <= ws_now;
        chg_d   <= chg;
        bcnt    <= (bcnt == CW'(WORD_BITS - 1)) ? '0 : bcnt + CW'(1);
        if (start && now_left) begin
          sh   <= pair_valid ? pair_left  : '0;
          rbuf <= pair_valid ? pair_right : '0;
        end else if (start) begin
          sh <= rbuf;
        end else begin
          sh <= {sh[WORD_BITS-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/stereo_serial_tx_chk.sv
module stereo_serial_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       pair_ready,
  input logic       sck_out,
  input logic       ws_out,
  input logic       sd_out,
  input logic       tick,
  input logic [3:0] cfg_q
);
  a_r1_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !cfg_q[3]) |-> (!sck_out && !ws_out));

  a_r4_ws_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && cfg_q[3] && (ws_out != $past(ws_out)))
      |-> ((sck_out != $past(sck_out)) && (sck_out == cfg_q[1])));

  a_r4_sd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && (sd_out != $past(sd_out))) |-> $past(tick));

  a_r7_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ready |=> !pair_ready);

  a_r7_ready_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ready |-> enable);

  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> (cfg_q == $past(cfg_q)));
endmodule

bind stereo_serial_tx stereo_serial_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .pair_ready (pair_ready),
  .sck_out    (sck_out),
  .ws_out     (ws_out),
  .sd_out     (sd_out),
  .tick       (tick),
  .cfg_q      ({m_c, lead_c, rise_c, swap_c})
);

// File: tb/tb_stereo_serial_tx.sv
module tb_stereo_serial_tx;
  localparam int W  = 16;
  localparam int HD = 2;
  localparam int SH = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, enable, c_m, c_lead, c_rise, c_swap, pair_valid, pair_ready;
  logic [W-1:0] pl, pr;
  logic sck_in, ws_in, sck_out, ws_out, sd_out;

  stereo_serial_tx #(.WORD_BITS(W), .HALF_DIV(HD)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_master(c_m), .cfg_ws_lead(c_lead), .cfg_rise_launch(c_rise), .cfg_ws_swap(c_swap),
    .pair_valid(pair_valid), .pair_ready(pair_ready), .pair_left(pl), .pair_right(pr),
    .sck_in(sck_in), .ws_in(ws_in), .sck_out(sck_out), .ws_out(ws_out), .sd_out(sd_out)
  );

  typedef struct packed { logic left; logic [W-1:0] v; } item_t;
  item_t q[$];
  item_t exp_it;

  int checks = 0, fails = 0;
  bit done = 0;
  bit run_m = 0, run_lead = 0, run_rise = 0, run_swap = 0, slv_run = 0;
  bit len_bad, edge_bad, quiet_bad, per_bad;
  int cyc = 0, gdiv, gcnt, cnt, lastc;
  bit first, seenc;
  logic pb, pws, pind, psd, pwo, pso, mb, mw, mind;
  logic [W-1:0] acc;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [W-1:0] mk(input int t, input int k, input int ch);
    return W'((t * 37 + k * 11 + ch * 5 + 3) * 32'h2D4B);
  endfunction

  // external timing master for slave runs
  always @(posedge clk) begin
    if (!slv_run) begin
      sck_in <= !run_rise;
      ws_in  <= !run_swap;
      gdiv   <= 0;
      gcnt   <= W - 1;
    end else if (gdiv == SH - 1) begin
      gdiv   <= 0;
      sck_in <= !sck_in;
      if (!sck_in == run_rise) begin
        if (gcnt == W - 1) begin
          gcnt  <= 0;
          ws_in <= !ws_in;
        end else gcnt <= gcnt + 1;
      end
    end else gdiv <= gdiv + 1;
  end

  // monitor: decode at the far-end sampling edge and score against the queue
  always @(negedge clk) begin
    cyc++;
    if (!enable) begin
      pb = !run_rise; pws = !run_swap; pind = !run_swap;
      cnt = 0; acc = '0; first = 1; seenc = 0;
    end else begin
      mb = run_m ? sck_out : sck_in;
      mw = run_m ? ws_out : ws_in;
      if (run_m) begin
        if (sck_out != pso) begin
          if (seenc && (cyc - lastc != HD)) per_bad = 1;
          seenc = 1; lastc = cyc;
        end
        if ((sd_out != psd || ws_out != pwo) && !(sck_out != pso && sck_out == run_rise))
          edge_bad = 1;
      end else if (sck_out || ws_out) quiet_bad = 1;
      if (mb != pb && mb == !run_rise) begin
        mind = run_lead ? pws : mw;
        if (mind != pind) begin
          if (!first && cnt != W) len_bad = 1;
          first = 0; cnt = 0; acc = '0;
        end
        acc = {acc[W-2:0], sd_out};
        cnt++;
        if (cnt == W) begin
          if (q.size() == 0) chk(0, run_lead ? "R3" : "R2", "unexpected word", 32'(acc), 0);
          else begin
            exp_it = q.pop_front();
            chk(acc == exp_it.v, run_lead ? "R3" : "R2", "word value", 32'(acc), 32'(exp_it.v));
            chk((mind == run_swap) == exp_it.left, "R5", "channel left flag",
                32'(mind == run_swap), 32'(exp_it.left));
          end
        end
        pind = mind; pws = mw;
      end
      pb = mb;
    end
    psd = sd_out; pwo = ws_out; pso = sck_out;
  end

  task automatic wait_ready();
    int n = 0;
    @(negedge clk);
    while (!pair_ready && n < 8000) begin @(negedge clk); n++; end
    if (!pair_ready) chk(0, "R7", "ready timeout", 0, 1);
  endtask

  task automatic run_cfg(input bit m, input bit lead, input bit rise, input bit swap, input int tag);
    int n;
    enable = 0; slv_run = 0;
    run_m = m; run_lead = lead; run_rise = rise; run_swap = swap;
    c_m = m; c_lead = lead; c_rise = rise; c_swap = swap;
    len_bad = 0; edge_bad = 0; quiet_bad = 0; per_bad = 0;
    pair_valid = 1; pl = mk(tag, 0, 0); pr = mk(tag, 0, 1);
    repeat (6) @(posedge clk);
    #1;
    enable = 1; slv_run = !m;
    // R8: flip every configuration input while running
    c_m = !m; c_lead = !lead; c_rise = !rise; c_swap = !swap;
    for (int k = 0; k < 3; k++) begin
      wait_ready();
      q.push_back(item_t'{1'b1, pl});
      q.push_back(item_t'{1'b0, pr});
      @(posedge clk);
      #1;
      pl = mk(tag, k + 1, 0); pr = mk(tag, k + 1, 1);
    end
    pair_valid = 0;
    wait_ready();
    q.push_back(item_t'{1'b1, '0});  // R7 zero frame
    q.push_back(item_t'{1'b0, '0});
    @(posedge clk);
    #1;
    n = 0;
    while (q.size() != 0 && n < 8000) begin @(negedge clk); n++; end
    chk(q.size() == 0, "R8", "words left undecoded", q.size(), 0);
    q.delete();
    #1;
    enable = 0; slv_run = 0;
    chk(!len_bad, "R6", "word-select hold length", 32'(len_bad), 0);
    if (m) begin
      chk(!per_bad, "R1", "sck half period", 32'(per_bad), 0);
      chk(!edge_bad, "R4", "change off launch edge", 32'(edge_bad), 0);
    end else chk(!quiet_bad, "R1", "slave lines quiet", 32'(quiet_bad), 0);
  endtask

  initial begin
    rst_n = 0; enable = 0; c_m = 0; c_lead = 0; c_rise = 0; c_swap = 0;
    pair_valid = 0; pl = '0; pr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(sck_out == 0, "R9", "reset sck_out", 32'(sck_out), 0);
    chk(ws_out == 0, "R9", "reset ws_out", 32'(ws_out), 0);
    chk(sd_out == 0, "R9", "reset sd_out", 32'(sd_out), 0);
    chk(pair_ready == 0, "R9", "reset pair_ready", 32'(pair_ready), 0);
    for (int c = 0; c < 16; c++) run_cfg(c[3], c[2], c[1], c[0], c);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(64'd200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule